// File: doc/BRIEF.md
# Phase-Gated Stretched Clock Generator

This block derives an asymmetric clock for an attached coprocessor from a fast system clock that completes a fixed number of ticks (seven by default) in every host bus cycle. The host bus divides each of its cycles into two phases. A phase input marks the first phase (Phi1). The generator flips its output on each fast tick only within a short burst at the start of Phi1. Each host cycle therefore yields three short half-periods followed by one long low half-period. The long half covers the rest of Phi1 and all of Phi0. The coprocessor clock stays phase-locked to the host bus, and its memory cycles line up with the phase in which the bus may be used.

A tick index restarts at every rising edge of the phase input. The burst occupies a fixed number of consecutive ticks. When the coprocessor memory interface needs extra alignment, it raises a sync request. The next burst then starts one tick later, so the preceding long half gains one short tick. A request is held until the next host cycle starts and applies to that one cycle only.

Top module: `stretch_clk_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first clock edge that samples a rising edge of `phi1_i`, `cpclk_o` is low and does not change.
- R2: `cpclk_o` changes only at a clock edge at which `phi1_i` is sampled high.
- R3: The edge that samples a rising `phi1_i` is tick 0, and each later edge adds one. In a cycle without a sync shift, `cpclk_o` toggles at ticks 0, 1, 2 and 3 (TOGGLES = 4 consecutive ticks). So the output is high after tick 0 and tick 2, and low after tick 1 and tick 3.
- R4: With Phi1 high for at least five ticks of each seven-tick host cycle, `cpclk_o` makes exactly four transitions per host cycle and is low when the next Phi1 rise is sampled.
- R5: If `sync_req_i` is sampled high at any edge after one Phi1 rise edge, or at the next Phi1 rise edge itself, the host cycle that begins at that next rise toggles at ticks 1 to 4 instead of 0 to 3.
- R6: A sync request shifts only one host cycle. The following cycle returns to ticks 0 to 3 unless a new request is sampled.
- R7: If Phi1 stays high past the burst, the tick index stops at 6 and `cpclk_o` makes no further transitions until the next Phi1 rise.
- R8: If the phase input never rises, `cpclk_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock, TICKS_PER_HOST ticks per host cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| phi1_i | input | 1 | Host phase, high during Phi1 |
| sync_req_i | input | 1 | Request to delay the next burst by one tick |
| cpclk_o | output | 1 | Stretched coprocessor clock |

## Verification
Two functions can act on the same clock edge: a sync request sampled at the edge where Phi1 rises, and the capture of the pending request into the new host cycle's shift. The bench raises `sync_req_i` exactly on tick 0 in directed cases. It also places it on random ticks, where it can land on the rise edge while an earlier request is still pending. It judges the result by whether the burst that just began starts at tick 1. It also checks that the cycle after that one returns to tick 0.

// File: rtl/stretch_clk_pkg.sv
package stretch_clk_pkg;
  parameter int unsigned TICKS_PER_HOST = 7;
  parameter int unsigned TOGGLES        = 4;
  localparam int unsigned TICK_W        = $clog2(TICKS_PER_HOST);
  typedef logic [TICK_W-1:0] tick_t;
endpackage

// File: rtl/stretch_phase_tracker.sv
module stretch_phase_tracker
  import stretch_clk_pkg::*;
#(
  parameter int unsigned TICKS = TICKS_PER_HOST
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  phi1_i,
  output logic  rise_o,
  output logic  started_o,
  output logic  running_o,
  output tick_t tick_o
);
  localparam tick_t LAST = tick_t'(TICKS - 1);

  logic  phi1_q;
  logic  started_q;
  tick_t tick_q;
  tick_t tick_d;

  assign rise_o = phi1_i & ~phi1_q;

  // saturate so a stuck phase never wraps back into the burst
  always_comb begin
    if (rise_o)              tick_d = '0;
    else if (tick_q == LAST) tick_d = LAST;
    else                     tick_d = tick_q + tick_t'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phi1_q    <= 1'b0;
      started_q <= 1'b0;
      tick_q    <= '0;
    end else begin
      phi1_q <= phi1_i;
      if (rise_o) started_q <= 1'b1;
      if (started_q || rise_o) tick_q <= tick_d;
    end
  end

  assign tick_o    = tick_d;
  assign started_o = started_q;
  assign running_o = started_q | rise_o;
endmodule

// File: rtl/stretch_sync_latch.sv
module stretch_sync_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic sync_req_i,
  output logic shift_o,
  output logic pend_o
);
  logic pend_q;
  logic shift_q;

  // a request on the rise edge itself applies to the cycle starting now
  assign shift_o = rise_i ? (pend_q | sync_req_i) : shift_q;
  assign pend_o  = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      shift_q <= 1'b0;
    end else begin
      shift_q <= shift_o;
      if (rise_i)          pend_q <= 1'b0;
      else if (sync_req_i) pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/stretch_toggle_gen.sv
module stretch_toggle_gen
  import stretch_clk_pkg::*;
#(
  parameter int unsigned NTOG = TOGGLES
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  phi1_i,
  input  logic  running_i,
  input  logic  shift_i,
  input  tick_t tick_i,
  output logic  clk_o
);
  localparam int unsigned EW = TICK_W + 2;
  typedef logic [EW-1:0] ext_t;

  ext_t lo;
  ext_t hi;
  ext_t cur;
  logic in_window;
  logic toggle;
  logic clk_q;

  assign cur       = ext_t'(tick_i);
  assign lo        = ext_t'(shift_i);
  assign hi        = lo + ext_t'(NTOG);
  assign in_window = (cur >= lo) && (cur < hi);
  assign toggle    = phi1_i & running_i & in_window;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_q <= 1'b0;
    else if (toggle) clk_q <= ~clk_q;
  end

  assign clk_o = clk_q;
endmodule

// File: rtl/stretch_clk_gen.sv
module stretch_clk_gen
  import stretch_clk_pkg::*;
#(
  parameter int unsigned TICKS = TICKS_PER_HOST,
  parameter int unsigned NTOG  = TOGGLES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phi1_i,
  input  logic sync_req_i,
  output logic cpclk_o
);
  logic  rise;
  logic  started;
  logic  running;
  logic  shift;
  logic  pend;
  tick_t tick_cur;

  stretch_phase_tracker #(.TICKS(TICKS)) i_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .phi1_i   (phi1_i),
    .rise_o   (rise),
    .started_o(started),
    .running_o(running),
    .tick_o   (tick_cur)
  );

  stretch_sync_latch i_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .sync_req_i(sync_req_i),
    .shift_o   (shift),
    .pend_o    (pend)
  );

  stretch_toggle_gen #(.NTOG(NTOG)) i_tog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .phi1_i   (phi1_i),
    .running_i(running),
    .shift_i  (shift),
    .tick_i   (tick_cur),
    .clk_o    (cpclk_o)
  );
endmodule

// File: rtl/stretch_clk_checker.sv
module stretch_clk_checker
  import stretch_clk_pkg::*;
#(
  parameter int unsigned TICKS = TICKS_PER_HOST
) (
  input logic  clk_i,
  input logic  rst_ni,
  input logic  phi1_i,
  input logic  cpclk_o,
  input logic  rise,
  input logic  started,
  input logic  shift,
  input logic  pend,
  input tick_t tick_cur
);
  a_r1_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started |-> !cpclk_o);

  a_r2_phase_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(phi1_i) |-> $stable(cpclk_o));

  a_r3_first_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && !shift) |=> (cpclk_o != $past(cpclk_o)));

  a_r4_low_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |-> !cpclk_o);

  a_r6_pend_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> !pend);

  a_r7_tick_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(tick_cur) <= TICKS - 1);
endmodule

bind stretch_clk_gen stretch_clk_checker #(.TICKS(TICKS)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .phi1_i  (phi1_i),
  .cpclk_o (cpclk_o),
  .rise    (rise),
  .started (started),
  .shift   (shift),
  .pend    (pend),
  .tick_cur(tick_cur)
);

// File: tb/test_stretch_clk_gen.sv
`timescale 1ns/1ps
module test_stretch_clk_gen;
  localparam int TICKS = 7;
  localparam int NTOG  = 4;
  localparam int PHI1_TICKS = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phi1 = 1'b0;
  logic sreq = 1'b0;
  logic cp;

  int n_checks = 0;
  int n_fail = 0;

  // bench model state
  logic m_phi1_prev, m_started, m_pend, m_shift, m_exp, m_rise;
  int   m_tick;
  int   edges;
  bit   have_cycle;
  logic last_cp;

  stretch_clk_gen i_stretch_clk_gen (
    .clk_i(clk), .rst_ni(rst_n), .phi1_i(phi1), .sync_req_i(sreq), .cpclk_o(cp)
  );

  always #5 clk = ~clk;

  initial begin
    #(200000 * 10);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit win(input int t, input logic sh);
    return (t >= int'(sh)) && (t < int'(sh) + NTOG);
  endfunction

  task automatic model_reset();
    m_phi1_prev = 0; m_started = 0; m_pend = 0; m_shift = 0; m_exp = 0;
    m_tick = 0; edges = 0; have_cycle = 0; last_cp = 0; m_rise = 0;
  endtask

  // drive one tick, then compare at the following negedge
  task automatic step(input logic p, input logic s, input string req);
    phi1 = p; sreq = s;
    @(posedge clk);
    m_rise = p & ~m_phi1_prev;
    if (m_rise) begin
      m_tick = 0; m_shift = m_pend | s; m_pend = 0; m_started = 1;
    end else begin
      if (m_tick < TICKS - 1) m_tick++;
      if (s) m_pend = 1;
    end
    if (p && m_started && win(m_tick, m_shift)) m_exp = ~m_exp;
    m_phi1_prev = p;
    @(negedge clk);
    check(cp === m_exp, req, int'(cp), int'(m_exp));
    if (m_rise) begin
      if (have_cycle) check(edges == NTOG, "R4 edge count", edges, NTOG);
      edges = 0; have_cycle = 1;
    end
    if (cp !== last_cp) edges++;
    last_cp = cp;
  endtask

  // one host cycle; mode 0 none, 1 sync on tick t_s, 2 random
  task automatic host_cycle(input int mode, input int t_s, input string req);
    for (int t = 0; t < TICKS; t++) begin
      logic s;
      s = (mode == 1) ? (t == t_s) : (mode == 2) ? (($urandom % 8) == 0) : 1'b0;
      step(t < PHI1_TICKS, s, req);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    check(cp === 1'b0, "R1 in reset", int'(cp), 0);
    rst_n = 1'b1;
    // R8/R1: no phase activity
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0, "R8 no phase");
    check(cp === 1'b0, "R1 before first rise", int'(cp), 0);
    // R3: directed tick-by-tick burst
    step(1'b1, 1'b0, "R3 tick0");
    check(cp === 1'b1, "R3 high after tick0", int'(cp), 1);
    step(1'b1, 1'b0, "R3 tick1");
    check(cp === 1'b0, "R3 low after tick1", int'(cp), 0);
    step(1'b1, 1'b0, "R3 tick2");
    step(1'b1, 1'b0, "R3 tick3");
    check(cp === 1'b0, "R3 low after tick3", int'(cp), 0);
    step(1'b1, 1'b0, "R3 tick4");
    step(1'b0, 1'b0, "R2 phi0");
    step(1'b0, 1'b0, "R2 phi0");
    repeat (3) host_cycle(0, 0, "R4 plain");
    // R5: request mid-cycle, then R6 return
    host_cycle(1, 5, "R5 request mid");
    step(1'b1, 1'b0, "R5 shifted tick0");
    check(cp === 1'b0, "R5 no toggle at tick0", int'(cp), 0);
    step(1'b1, 1'b0, "R5 shifted tick1");
    check(cp === 1'b1, "R5 toggle at tick1", int'(cp), 1);
    for (int t = 2; t < TICKS; t++) step(t < PHI1_TICKS, 1'b0, "R5 shifted");
    host_cycle(0, 0, "R6 unshifted after");
    // request on the rise edge itself
    host_cycle(1, 0, "R5 request at rise");
    host_cycle(0, 0, "R6 back to tick0");
    // R7: phase stuck high
    for (int i = 0; i < 15; i++) step(1'b1, 1'b0, "R7 stuck phase");
    check(cp === 1'b0, "R7 held after burst", int'(cp), 0);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R7 release");
    have_cycle = 0;
    // random mix
    for (int c = 0; c < 400; c++) host_cycle(2, 0, "R5 random");
    // mid-run reset
    step(1'b1, 1'b0, "R3 before reset");
    rst_n = 1'b0;
    #1;
    check(cp === 1'b0, "R1 async reset", int'(cp), 0);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, "R1 after reset");
    for (int c = 0; c < 50; c++) host_cycle(2, 0, "R6 random tail");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule